// File: doc/BRIEF.md
# Page Translation Unit with Victim Buffer and Directory Cache

This block turns a linear page number into a physical page entry. Its main store is a direct-mapped table of page entries. Two small fully associative stores sit beside it. The victim buffer keeps entries that a refill pushed out of the main table. The directory cache keeps the directory entries read most recently. A lookup is answered in the cycle it is presented: it either hits with the page entry or reports a miss. A miss starts a page walk, which reads one or two words from memory. Once the walk finishes, the requester presents the same lookup again.

The walk controller is a state machine with five states. `W_IDLE` accepts lookups. On a miss it moves to `W_PTE_ISSUE` if the directory cache already holds the directory entry, and to `W_DIR_ISSUE` if it does not. `W_DIR_ISSUE` sends the directory read for one cycle and moves to `W_DIR_WAIT`. `W_DIR_WAIT` waits for the response, stores the directory entry and moves to `W_PTE_ISSUE`. `W_PTE_ISSUE` sends the page entry read and moves to `W_PTE_WAIT`. `W_PTE_WAIT` waits for the response, refills the main table and returns to `W_IDLE`. A flush returns every state to `W_IDLE`.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, all three stores are empty, `lk_ready` is 1 and `mem_req_valid` is 0.
- R2: The main table is indexed by `lk_vpn[IDX_W-1:0]` and tagged with the remaining upper bits. A lookup accepted while `lk_ready` is 1 that matches a valid main line drives `lk_hit`=1, `lk_from_victim`=0 and the stored entry on `lk_pte` in the same cycle.
- R3: A lookup that misses in every store produces two memory reads, one cycle each and in this order. The first is the directory read: `mem_req_dir`=1, with `mem_req_addr` equal to the zero-extended directory index `lk_vpn[VPN_W-1:VPN_W-DIR_W]`. The second is the page entry read: `mem_req_dir`=0, with `mem_req_addr` = {directory response, `lk_vpn[VPN_W-DIR_W-1:0]`}. The page entry response then refills the main line, so the next lookup of the same page hits.
- R4: A miss whose directory index is held in the directory cache produces only the page entry read.
- R5: The directory cache holds DC_N entries (4 by default). When it is full and a new entry is inserted, the entry inserted earliest is replaced.
- R6: A refill that overwrites a valid main line moves the old entry into the victim buffer. A later lookup of that page hits with `lk_from_victim`=1 and the correct entry, in the same cycle.
- R7: On a victim hit, the victim entry and the conflicting main line exchange places at the next clock edge. Afterwards the looked-up page hits in the main table and the page that was displaced hits in the victim buffer.
- R8: The victim buffer holds VIC_N entries (8 by default). When it is full, a new eviction replaces its oldest entry, and that page misses afterwards.
- R9: A one-cycle `flush` invalidates every entry of all three stores. After it, a previously cached page misses and needs both reads.
- R10: While a walk is in progress, `lk_ready` is 0. Lookups presented then drive neither `lk_hit` nor `lk_miss` and start no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all stores and abort any walk |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Linear page number to translate |
| lk_ready | output | 1 | Unit is idle and accepts lookups |
| lk_hit | output | 1 | Translation found this cycle |
| lk_from_victim | output | 1 | The hit came from the victim buffer |
| lk_miss | output | 1 | Translation absent; a walk starts |
| lk_pte | output | PTE_W | Page entry returned on a hit |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_dir | output | 1 | 1 for a directory read, 0 for a page entry read |
| mem_req_addr | output | PTE_W+VPN_W-DIR_W | Read address |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | PTE_W | Read data |

## Verification
The bench builds the unit with its defaults: 20-bit page numbers, a 10-bit directory index, 128 main lines, 8 victim slots and 4 directory slots. Ten pages that share the same low seven bits all compete for one main line, which is enough to fill the victim buffer past capacity and push out its oldest entry. Five distinct directory indices overflow the directory cache. A memory model in the bench counts the directory reads and the page entry reads separately, so the one-read and two-read walks can be told apart at the ports.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
    typedef enum logic [2:0] {
        W_IDLE,
        W_DIR_ISSUE,
        W_DIR_WAIT,
        W_PTE_ISSUE,
        W_PTE_WAIT
    } walk_state_t;
endpackage

// File: rtl/tlb_direct_array.sv
module tlb_direct_array #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 13,
    parameter int VAL_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [VAL_W-1:0] rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [VAL_W-1:0] wr_val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [VAL_W-1:0] val_q [DEPTH];

    assign rd_valid = vld[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_val   = val_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vld <= '0;
        else if (flush) vld <= '0;
        else if (wr_en) vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            val_q[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/tlb_fifo_cam.sv
module tlb_fifo_cam #(
    parameter int DEPTH = 8,
    parameter int KEY_W = 20,
    parameter int VAL_W = 24,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [KEY_W-1:0]  q_key,
    output logic              q_hit,
    output logic [SLOT_W-1:0] q_slot,
    output logic [VAL_W-1:0]  q_val,
    input  logic              push_en,
    input  logic [KEY_W-1:0]  push_key,
    input  logic [VAL_W-1:0]  push_val,
    input  logic              put_en,
    input  logic [SLOT_W-1:0] put_slot,
    input  logic              put_valid,
    input  logic [KEY_W-1:0]  put_key,
    input  logic [VAL_W-1:0]  put_val
);
    logic [DEPTH-1:0]  vld;
    logic [DEPTH-1:0]  match;
    logic [KEY_W-1:0]  key_q [DEPTH];
    logic [VAL_W-1:0]  val_q [DEPTH];
    logic [SLOT_W-1:0] oldest;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld[g] && (key_q[g] == q_key);
    end

    always_comb begin
        q_hit  = |match;
        q_slot = '0;
        for (int i = 0; i < DEPTH; i++)
            if (match[i]) q_slot = SLOT_W'(i);
        q_val = val_q[q_slot];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld    <= '0;
            oldest <= '0;
        end else if (flush) begin
            vld    <= '0;
            oldest <= '0;
        end else begin
            if (push_en) begin
                vld[oldest] <= 1'b1;
                oldest <= (oldest == SLOT_W'(DEPTH-1)) ? '0 : oldest + 1'b1;
            end
            if (put_en) vld[put_slot] <= put_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) begin
            key_q[oldest] <= push_key;
            val_q[oldest] <= push_val;
        end
        if (put_en) begin
            key_q[put_slot] <= put_key;
            val_q[put_slot] <= put_val;
        end
    end
endmodule

// File: rtl/tlb_walk_ctrl.sv
module tlb_walk_ctrl
    import tlb_xlate_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int DIR_W = 10,
    parameter int PTE_W = 24,
    localparam int TBL_W  = VPN_W - DIR_W,
    localparam int ADDR_W = PTE_W + TBL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  logic [VPN_W-1:0]  start_vpn,
    input  logic              dc_hit,
    input  logic [PTE_W-1:0]  dc_val,
    input  logic              resp_valid,
    input  logic [PTE_W-1:0]  resp_data,
    output logic              ready,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic              req_valid,
    output logic              req_dir,
    output logic [ADDR_W-1:0] req_addr,
    output logic              dc_push,
    output logic              fill_en
);
    walk_state_t state, nxt;
    logic [VPN_W-1:0] vpn_q;
    logic [PTE_W-1:0] dte_q;

    always_comb begin
        nxt = state;
        unique case (state)
            W_IDLE:      if (start) nxt = dc_hit ? W_PTE_ISSUE : W_DIR_ISSUE;
            W_DIR_ISSUE: nxt = W_DIR_WAIT;
            W_DIR_WAIT:  if (resp_valid) nxt = W_PTE_ISSUE;
            W_PTE_ISSUE: nxt = W_PTE_WAIT;
            W_PTE_WAIT:  if (resp_valid) nxt = W_IDLE;
            default:     nxt = W_IDLE;
        endcase
        if (flush) nxt = W_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (state == W_IDLE && start) begin
            vpn_q <= start_vpn;
            if (dc_hit) dte_q <= dc_val;
        end
        if (state == W_DIR_WAIT && resp_valid) dte_q <= resp_data;
    end

    always_comb begin
        ready     = (state == W_IDLE);
        req_valid = (state == W_DIR_ISSUE) || (state == W_PTE_ISSUE);
        req_dir   = (state == W_DIR_ISSUE);
        req_addr  = req_dir ? {{(ADDR_W-DIR_W){1'b0}}, vpn_q[VPN_W-1:TBL_W]}
                            : {dte_q, vpn_q[TBL_W-1:0]};
        dc_push   = (state == W_DIR_WAIT) && resp_valid && !flush;
        fill_en   = (state == W_PTE_WAIT) && resp_valid && !flush;
        walk_vpn  = vpn_q;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
    parameter int VPN_W = 20,
    parameter int DIR_W = 10,
    parameter int IDX_W = 7,
    parameter int PTE_W = 24,
    parameter int VIC_N = 8,
    parameter int DC_N  = 4,
    localparam int TBL_W  = VPN_W - DIR_W,
    localparam int TAG_W  = VPN_W - IDX_W,
    localparam int ADDR_W = PTE_W + TBL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_ready,
    output logic              lk_hit,
    output logic              lk_from_victim,
    output logic              lk_miss,
    output logic [PTE_W-1:0]  lk_pte,
    output logic              mem_req_valid,
    output logic              mem_req_dir,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [PTE_W-1:0]  mem_resp_data
);
    localparam int VSLOT_W = (VIC_N > 1) ? $clog2(VIC_N) : 1;
    localparam int DSLOT_W = (DC_N > 1) ? $clog2(DC_N) : 1;

    logic               active, m_hit, v_hit, d_hit, swap, fill_en, dc_push;
    logic [VPN_W-1:0]   walk_vpn;
    logic [IDX_W-1:0]   rd_idx, wr_idx;
    logic               rd_valid;
    logic [TAG_W-1:0]   rd_tag, wr_tag;
    logic [PTE_W-1:0]   rd_val, wr_val, v_val, d_val;
    logic [VSLOT_W-1:0] v_slot;
    logic [DSLOT_W-1:0] d_slot;

    assign active = lk_valid && lk_ready && !flush;
    assign rd_idx = lk_ready ? lk_vpn[IDX_W-1:0] : walk_vpn[IDX_W-1:0];
    assign m_hit  = rd_valid && (rd_tag == lk_vpn[VPN_W-1:IDX_W]);
    assign swap   = active && !m_hit && v_hit;

    assign lk_hit         = active && (m_hit || v_hit);
    assign lk_from_victim = swap;
    assign lk_miss        = active && !m_hit && !v_hit;
    assign lk_pte         = m_hit ? rd_val : v_val;

    always_comb begin
        if (fill_en) begin
            wr_idx = walk_vpn[IDX_W-1:0];
            wr_tag = walk_vpn[VPN_W-1:IDX_W];
            wr_val = mem_resp_data;
        end else begin
            wr_idx = lk_vpn[IDX_W-1:0];
            wr_tag = lk_vpn[VPN_W-1:IDX_W];
            wr_val = v_val;
        end
    end

    tlb_direct_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .VAL_W(PTE_W)) u_main (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_val(rd_val),
        .wr_en(fill_en || swap), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_val(wr_val)
    );

    tlb_fifo_cam #(.DEPTH(VIC_N), .KEY_W(VPN_W), .VAL_W(PTE_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .q_key(lk_vpn), .q_hit(v_hit), .q_slot(v_slot), .q_val(v_val),
        .push_en(fill_en && rd_valid), .push_key({rd_tag, rd_idx}), .push_val(rd_val),
        .put_en(swap), .put_slot(v_slot), .put_valid(rd_valid),
        .put_key({rd_tag, rd_idx}), .put_val(rd_val)
    );

    tlb_fifo_cam #(.DEPTH(DC_N), .KEY_W(DIR_W), .VAL_W(PTE_W)) u_dircache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .q_key(lk_vpn[VPN_W-1:TBL_W]), .q_hit(d_hit), .q_slot(d_slot), .q_val(d_val),
        .push_en(dc_push), .push_key(walk_vpn[VPN_W-1:TBL_W]), .push_val(mem_resp_data),
        .put_en(1'b0), .put_slot(d_slot), .put_valid(1'b0),
        .put_key(lk_vpn[VPN_W-1:TBL_W]), .put_val(d_val)
    );

    tlb_walk_ctrl #(.VPN_W(VPN_W), .DIR_W(DIR_W), .PTE_W(PTE_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .start(lk_miss), .start_vpn(lk_vpn), .dc_hit(d_hit), .dc_val(d_val),
        .resp_valid(mem_resp_valid), .resp_data(mem_resp_data),
        .ready(lk_ready), .walk_vpn(walk_vpn),
        .req_valid(mem_req_valid), .req_dir(mem_req_dir), .req_addr(mem_req_addr),
        .dc_push(dc_push), .fill_en(fill_en)
    );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             lk_valid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_ready,
    input logic             lk_hit,
    input logic             lk_from_victim,
    input logic             lk_miss,
    input logic             mem_req_valid
);
    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |-> (!lk_hit && !lk_miss));

    // R3
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R3
    req_while_walking_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !lk_ready);

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R2
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R7
    swap_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit && lk_from_victim && !flush) ##1
        (lk_valid && !flush && lk_vpn == $past(lk_vpn)) |-> (lk_hit && !lk_from_victim));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VPN_W(VPN_W)) u_chk (.*);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
    localparam int VPN_W = 20, DIR_W = 10, PTE_W = 24;
    localparam int ADDR_W = PTE_W + VPN_W - DIR_W;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic lk_ready, lk_hit, lk_from_victim, lk_miss, mem_req_valid, mem_req_dir;
    logic [PTE_W-1:0] lk_pte;
    logic [ADDR_W-1:0] mem_req_addr;
    logic mem_resp_valid = 1'b0;
    logic [PTE_W-1:0] mem_resp_data = '0;

    int checks = 0, errors = 0, n_dir = 0, n_pte = 0;
    logic [ADDR_W-1:0] last_dir_addr, last_pte_addr, pend_addr;
    logic pend = 1'b0, pend_dir = 1'b0;

    always #2.5 clk = ~clk;

    tlb_xlate uut (.*);

    function automatic logic [PTE_W-1:0] dte_of(input logic [DIR_W-1:0] d);
        return {d, d, 4'hA} ^ 24'h5A3C1E;
    endfunction
    function automatic logic [PTE_W-1:0] pte_of_addr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:10] ^ {14'h0, a[9:0]} ^ 24'h0F1357;
    endfunction
    function automatic logic [PTE_W-1:0] pte_of(input logic [VPN_W-1:0] v);
        return pte_of_addr({dte_of(v[19:10]), v[9:0]});
    endfunction

    // memory model: answers each read one cycle after the request
    always @(negedge clk) begin
        mem_resp_valid <= 1'b0;
        if (pend) begin
            mem_resp_valid <= 1'b1;
            mem_resp_data  <= pend_dir ? dte_of(pend_addr[DIR_W-1:0]) : pte_of_addr(pend_addr);
            pend <= 1'b0;
        end
        if (mem_req_valid) begin
            pend <= 1'b1;
            pend_dir <= mem_req_dir;
            pend_addr <= mem_req_addr;
            if (mem_req_dir) begin n_dir++; last_dir_addr <= mem_req_addr; end
            else begin n_pte++; last_pte_addr <= mem_req_addr; end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one lookup; on a miss waits until the walk is over
    task automatic look(input logic [VPN_W-1:0] v, output logic hit, output logic fv,
                        output logic miss, output logic [PTE_W-1:0] pte,
                        output int rd_dir, output int rd_pte);
        int d0, p0;
        @(negedge clk);
        d0 = n_dir; p0 = n_pte;
        lk_valid = 1'b1; lk_vpn = v;
        #1;
        hit = lk_hit; fv = lk_from_victim; miss = lk_miss; pte = lk_pte;
        @(negedge clk);
        lk_valid = 1'b0;
        while (!lk_ready) @(negedge clk);
        @(negedge clk);
        rd_dir = n_dir - d0; rd_pte = n_pte - p0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    logic h, fv, m;
    logic [PTE_W-1:0] p;
    int nd, np;

    task automatic t_reset();
        #1;
        chk(lk_ready == 1'b1, "R1 ready after reset", 64'(lk_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R1 no request after reset", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_cold_walk();
        logic [VPN_W-1:0] a = {10'h012, 10'h055};
        look(a, h, fv, m, p, nd, np);
        chk(m && !h, "R3 cold miss", 64'(m), 64'd1);
        chk(nd == 1 && np == 1, "R3 two reads", 64'(nd * 16 + np), 64'h11);
        chk(last_dir_addr == ADDR_W'(10'h012), "R3 directory address", 64'(last_dir_addr), 64'h12);
        chk(last_pte_addr == {dte_of(10'h012), 10'h055}, "R3 entry address",
            64'(last_pte_addr), 64'({dte_of(10'h012), 10'h055}));
        look(a, h, fv, m, p, nd, np);
        chk(h && !fv && !m, "R2 main hit after refill", 64'({h, fv, m}), 64'b100);
        chk(p == pte_of(a), "R2 hit entry", 64'(p), 64'(pte_of(a)));
    endtask

    task automatic t_dir_hit();
        logic [VPN_W-1:0] v = {10'h012, 10'h2AA};
        look(v, h, fv, m, p, nd, np);
        chk(m && nd == 0 && np == 1, "R4 single read", 64'(nd * 16 + np), 64'h01);
        look(v, h, fv, m, p, nd, np);
        chk(h && p == pte_of(v), "R4 entry after short walk", 64'(p), 64'(pte_of(v)));
    endtask

    task automatic t_busy_ignored();
        logic [VPN_W-1:0] a = {10'h012, 10'h055};
        int d0, p0;
        @(negedge clk);
        d0 = n_dir; p0 = n_pte;
        lk_valid = 1'b1; lk_vpn = {10'h0F0, 10'h001};
        @(negedge clk);
        lk_vpn = a;
        #1;
        chk(!lk_ready && !lk_hit && !lk_miss, "R10 lookup ignored while busy",
            64'({lk_ready, lk_hit, lk_miss}), 64'b000);
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        chk((n_dir - d0) == 1 && (n_pte - p0) == 1, "R10 no extra reads",
            64'((n_dir - d0) * 16 + (n_pte - p0)), 64'h11);
    endtask

    task automatic t_victim_swap();
        logic [VPN_W-1:0] a = {10'h012, 10'h055};
        logic [VPN_W-1:0] b = {10'h012, 10'h0D5};
        look(b, h, fv, m, p, nd, np);
        chk(m, "R6 conflict miss", 64'(m), 64'd1);
        look(a, h, fv, m, p, nd, np);
        chk(h && fv, "R6 victim hit", 64'({h, fv}), 64'b11);
        chk(p == pte_of(a), "R6 victim entry", 64'(p), 64'(pte_of(a)));
        look(a, h, fv, m, p, nd, np);
        chk(h && !fv, "R7 swapped into main", 64'({h, fv}), 64'b10);
        look(b, h, fv, m, p, nd, np);
        chk(h && fv && p == pte_of(b), "R7 displaced entry in victim", 64'({h, fv}), 64'b11);
    endtask

    task automatic t_victim_oldest();
        do_flush();
        for (int k = 0; k < 10; k++)
            look({10'h100 + 10'(k >> 3), 3'(k), 7'h33}, h, fv, m, p, nd, np);
        look({10'h100, 3'd1, 7'h33}, h, fv, m, p, nd, np);
        chk(h && fv, "R8 second-oldest kept", 64'({h, fv}), 64'b11);
        look({10'h100, 3'd0, 7'h33}, h, fv, m, p, nd, np);
        chk(m && !h, "R8 oldest replaced", 64'({h, m}), 64'b01);
        look({10'h100, 3'd0, 7'h33}, h, fv, m, p, nd, np);
        chk(h && p == pte_of({10'h100, 3'd0, 7'h33}), "R8 refetched entry", 64'(p),
            64'(pte_of({10'h100, 3'd0, 7'h33})));
    endtask

    task automatic t_flush();
        do_flush();
        look({10'h100, 3'd0, 7'h33}, h, fv, m, p, nd, np);
        chk(m && nd == 1 && np == 1, "R9 main and directory cleared", 64'({m, 4'(nd), 4'(np)}), 64'h111);
        look({10'h100, 3'd2, 7'h33}, h, fv, m, p, nd, np);
        chk(m, "R9 victim cleared", 64'(m), 64'd1);
    endtask

    task automatic t_dir_oldest();
        do_flush();
        for (int k = 0; k < 5; k++)
            look({10'h200 + 10'(k), 10'h001}, h, fv, m, p, nd, np);
        look({10'h200, 10'h010}, h, fv, m, p, nd, np);
        chk(nd == 1 && np == 1, "R5 oldest directory replaced", 64'(nd * 16 + np), 64'h11);
        look({10'h204, 10'h011}, h, fv, m, p, nd, np);
        chk(nd == 0 && np == 1, "R5 newest directory kept", 64'(nd * 16 + np), 64'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_walk();
        t_dir_hit();
        t_busy_ignored();
        t_victim_swap();
        t_victim_oldest();
        t_flush();
        t_dir_oldest();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule